// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Codec for a 39-Bit Memory Word

This block protects a 32-bit memory doubleword with seven redundant bits. The encoder side takes the 32 data bits and produces six Hamming check bits and one overall parity bit. The stored word is then 39 bits wide:

- data bits sit at positions 0 to 31, with the low 16 forming the even word and the high 16 the odd word;
- check bits hc0 to hc5 sit at positions 32 to 37;
- the overall parity bit sits at position 38.

The decoder side takes a 39-bit word read back from memory. It reports:

- the 6-bit syndrome;
- whether the word holds a single error, a double error, or a syndrome that matches no bit position;
- the index of the failing bit;
- the data, corrected when correction is enabled.

The check matrix is fixed by a syndrome-to-bit map. Each check bit owns a one-hot syndrome, and each data bit owns a multi-bit code. Any syndrome that names no bit is treated as invalid.

Both paths are purely combinational, with no clock and no storage. The block therefore has no state machine. The encoder and decoder share one syndrome generator. A locator turns a syndrome into a bit index.

Top module: `secded39_codec`

## Requirements
- R1: For any 32-bit data, the encoder sets check bit hcK (position 32+K) to the XOR of all data bits whose code has syndrome bit 5-K set. It sets bit 38 so that all 39 bits have even parity. A word written this way decodes with syndrome 0, no flag raised, error index 0 and output data equal to the stored data.
- R2: Check bit hcK contributes the one-hot syndrome 1<<(5-K). Flipping position 32+K alone gives that syndrome, a single error, index 32+K, and data unchanged.
- R3: Data bit i contributes its fixed code. The codes for bits 0 to 31 are, in bit order: 48,40,24,56,36,20,52,12,44,28,60,34,18,50,10,42,26,58,6,38,22,54,14,46,30,62,33,17,49,9,41,25. Flipping data bit i alone gives that code as syndrome, a single error, and index i.
- R4: With correct_en high, a single error at a data position is corrected, so the output data equals the stored data.
- R5: With correct_en low, the output data equals bits 31:0 of the word read, even when a single error is flagged.
- R6: A word with syndrome 0 and odd overall parity is a single error at index 38, and the data is unchanged.
- R7: A word with a nonzero syndrome and even overall parity (any two flipped bits) raises the double-error flag only. The syndrome is the XOR of the two bits' codes, the index is 0, and the data is not corrected.
- R8: A word with odd overall parity and a nonzero syndrome that is neither one-hot nor a data code raises the bad-syndrome flag only. The index is 0 and the data is not altered.
- R9: At most one of the single, double and bad-syndrome flags is high at a time. The error index reads 0 whenever the single-error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data | input | 32 | Data to encode |
| enc_check | output | 7 | Redundant bits for positions 38:32 (parity, hc5..hc0) |
| dec_word | input | 39 | Word read from memory |
| correct_en | input | 1 | Enable correction of a single data-bit error |
| dec_data | output | 32 | Data out, corrected when enabled |
| syndrome | output | 6 | Computed syndrome |
| single_err | output | 1 | Single error located |
| double_err | output | 1 | Double error detected |
| bad_syndrome | output | 1 | Odd parity with a syndrome naming no bit |
| err_index | output | 6 | Index 0..38 of the failing bit when single_err |

## Verification
The bad-syndrome outcome is the hardest to reach from the ports. A single flip always lands on a valid syndrome, and an even number of flips keeps parity even. The stimulus therefore flips three check bits at once, hc5, hc4 and hc3. This gives syndrome 7 with odd parity, a value that names no bit. A second triple adds one data bit to two check bits so that the syndrome misses the map. Every single flip and every flip pair over all 39 positions is also driven on random data.

// File: rtl/secded39_pkg.sv
package secded39_pkg;
    localparam int DATA_W  = 32;
    localparam int CHK_W   = 6;
    localparam int PROT_W  = DATA_W + CHK_W;   // bits covered by the syndrome
    localparam int WORD_W  = PROT_W + 1;       // plus overall parity
    localparam int IDX_W   = 6;
    localparam int PAR_POS = PROT_W;           // position 38

    typedef logic [CHK_W-1:0] syn_t;

    // Syndrome code owned by each data bit
    function automatic syn_t data_code(input int i);
        case (i)
            0:  return 6'd48;  1:  return 6'd40;  2:  return 6'd24;  3:  return 6'd56;
            4:  return 6'd36;  5:  return 6'd20;  6:  return 6'd52;  7:  return 6'd12;
            8:  return 6'd44;  9:  return 6'd28;  10: return 6'd60;  11: return 6'd34;
            12: return 6'd18;  13: return 6'd50;  14: return 6'd10;  15: return 6'd42;
            16: return 6'd26;  17: return 6'd58;  18: return 6'd6;   19: return 6'd38;
            20: return 6'd22;  21: return 6'd54;  22: return 6'd14;  23: return 6'd46;
            24: return 6'd30;  25: return 6'd62;  26: return 6'd33;  27: return 6'd17;
            28: return 6'd49;  29: return 6'd9;   30: return 6'd41;  31: return 6'd25;
            default: return '0;
        endcase
    endfunction

    // Code of any protected position: data codes, then one-hot check bits
    function automatic syn_t pos_code(input int i);
        if (i < DATA_W) return data_code(i);
        return syn_t'(1) << (PROT_W - 1 - i);
    endfunction
endpackage

// File: rtl/secded39_syndrome.sv
module secded39_syndrome
    import secded39_pkg::*;
(
    input  logic [PROT_W-1:0] bits,
    output syn_t              syn
);
    syn_t term [PROT_W];

    genvar g;
    generate
        for (g = 0; g < PROT_W; g++) begin : g_term
            assign term[g] = bits[g] ? pos_code(g) : '0;
        end
    endgenerate

    always_comb begin
        syn = '0;
        for (int i = 0; i < PROT_W; i++) syn ^= term[i];
    end
endmodule

// File: rtl/secded39_locate.sv
module secded39_locate
    import secded39_pkg::*;
(
    input  syn_t             syn,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < PROT_W; i++) begin
            if (syn == pos_code(i)) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/secded39_encoder.sv
module secded39_encoder
    import secded39_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W:0]    check    // {parity, hc5..hc0}
);
    syn_t             dsyn;
    logic [CHK_W-1:0] hc;

    secded39_syndrome u_syn (
        .bits ({{CHK_W{1'b0}}, data}),
        .syn  (dsyn)
    );

    genvar k;
    generate
        for (k = 0; k < CHK_W; k++) begin : g_hc
            assign hc[k] = dsyn[CHK_W-1-k];
        end
    endgenerate

    assign check = {^{hc, data}, hc};
endmodule

// File: rtl/secded39_codec.sv
module secded39_codec
    import secded39_pkg::*;
(
    input  logic [31:0] enc_data,
    output logic [6:0]  enc_check,
    input  logic [38:0] dec_word,
    input  logic        correct_en,
    output logic [31:0] dec_data,
    output logic [5:0]  syndrome,
    output logic        single_err,
    output logic        double_err,
    output logic        bad_syndrome,
    output logic [5:0]  err_index
);
    syn_t             syn;
    logic             perr;
    logic             hit;
    logic [IDX_W-1:0] loc;
    logic [DATA_W-1:0] raw;

    secded39_encoder u_enc (
        .data  (enc_data),
        .check (enc_check)
    );

    secded39_syndrome u_dsyn (
        .bits (dec_word[PROT_W-1:0]),
        .syn  (syn)
    );

    secded39_locate u_loc (
        .syn (syn),
        .hit (hit),
        .idx (loc)
    );

    assign raw      = dec_word[DATA_W-1:0];
    assign perr     = ^dec_word;
    assign syndrome = syn;

    always_comb begin
        single_err   = 1'b0;
        double_err   = 1'b0;
        bad_syndrome = 1'b0;
        err_index    = '0;
        dec_data     = raw;
        if (perr) begin
            if (syn == '0) begin
                single_err = 1'b1;
                err_index  = IDX_W'(PAR_POS);
            end else if (hit) begin
                single_err = 1'b1;
                err_index  = loc;
                if (correct_en && int'(loc) < DATA_W)
                    dec_data = raw ^ (DATA_W'(1) << loc);
            end else begin
                bad_syndrome = 1'b1;
            end
        end else if (syn != '0) begin
            double_err = 1'b1;
        end
    end

    always_comb begin
        assert_flags_exclusive_R9: assert ($onehot0({single_err, double_err, bad_syndrome}))
            else $error("more than one error flag high");
        assert_index_idle_R9: assert (single_err || err_index == '0)
            else $error("index nonzero without single error");
        assert_double_uncorrected_R7: assert (!double_err || dec_data == raw)
            else $error("double error altered data");
        assert_bad_untouched_R8: assert (!bad_syndrome || (dec_data == raw && err_index == '0))
            else $error("bad syndrome altered outputs");
        assert_one_bit_fix_R4: assert (!(single_err && correct_en && err_index < 6'd32)
                                       || $countones(dec_data ^ raw) == 1)
            else $error("correction did not flip exactly one bit");
        assert_quiet_R1: assert (perr || syn != '0 || !(single_err || double_err || bad_syndrome))
            else $error("flag on a clean word");
    end
endmodule

// File: tb/secded39_codec_test.sv
module secded39_codec_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [31:0] enc_data;
    logic [6:0]  enc_check;
    logic [38:0] dec_word;
    logic        correct_en;
    logic [31:0] dec_data;
    logic [5:0]  syndrome;
    logic        single_err, double_err, bad_syndrome;
    logic [5:0]  err_index;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    secded39_codec uut (
        .enc_data(enc_data), .enc_check(enc_check), .dec_word(dec_word),
        .correct_en(correct_en), .dec_data(dec_data), .syndrome(syndrome),
        .single_err(single_err), .double_err(double_err),
        .bad_syndrome(bad_syndrome), .err_index(err_index)
    );

    bit [5:0] dmap [32] = '{6'd48, 6'd40, 6'd24, 6'd56, 6'd36, 6'd20, 6'd52, 6'd12,
                            6'd44, 6'd28, 6'd60, 6'd34, 6'd18, 6'd50, 6'd10, 6'd42,
                            6'd26, 6'd58, 6'd6,  6'd38, 6'd22, 6'd54, 6'd14, 6'd46,
                            6'd30, 6'd62, 6'd33, 6'd17, 6'd49, 6'd9,  6'd41, 6'd25};

    function automatic bit [5:0] code_at(int p);
        if (p < 32) return dmap[p];
        if (p < 38) return 6'(1 << (37 - p));
        return 6'd0;
    endfunction

    function automatic bit [6:0] ref_check(bit [31:0] d);
        bit [5:0] s = '0;
        bit [5:0] hc;
        for (int i = 0; i < 32; i++) if (d[i]) s ^= dmap[i];
        for (int k = 0; k < 6; k++) hc[k] = s[5 - k];
        return {^{hc, d}, hc};
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(bit [31:0] d, bit [38:0] flip, bit cen);
        @(posedge clk);
        enc_data   = d;
        dec_word   = {ref_check(d), d} ^ flip;
        correct_en = cen;
        @(negedge clk);
    endtask

    task automatic test_clean(bit [31:0] d);
        drive(d, '0, 1'b1);
        check(enc_check == ref_check(d), "R1 check bits", enc_check, ref_check(d));
        check(syndrome == 0 && !single_err && !double_err && !bad_syndrome,
              "R1 clean flags", {syndrome, single_err, double_err, bad_syndrome}, 0);
        check(dec_data == d && err_index == 0, "R1 clean data", dec_data, d);
    endtask

    task automatic test_singles(bit [31:0] d, bit cen);
        for (int p = 0; p < 39; p++) begin
            bit [38:0] f = 39'd1 << p;
            bit [31:0] exp_d = (cen || p >= 32) ? d : (d ^ f[31:0]);
            drive(d, f, cen);
            if (p == 38)
                check(syndrome == 0 && single_err && err_index == 38 && dec_data == d,
                      "R6 parity bit", {syndrome, err_index}, 38);
            else if (p >= 32)
                check(syndrome == code_at(p) && single_err && err_index == p && dec_data == d,
                      "R2 check bit", {syndrome, err_index}, {code_at(p), 6'(p)});
            else
                check(syndrome == code_at(p) && single_err && err_index == p,
                      "R3 data bit", {syndrome, err_index}, {code_at(p), 6'(p)});
            check(dec_data == exp_d, cen ? "R4 corrected" : "R5 raw pass", dec_data, exp_d);
            check(!double_err && !bad_syndrome, "R9 flags single",
                  {double_err, bad_syndrome}, 0);
        end
    endtask

    task automatic test_doubles(bit [31:0] d);
        for (int a = 0; a < 39; a++) begin
            for (int b = a + 1; b < 39; b++) begin
                bit [38:0] f = (39'd1 << a) | (39'd1 << b);
                bit [5:0] es = code_at(a) ^ code_at(b);
                drive(d, f, 1'b1);
                check(double_err && !single_err && !bad_syndrome && err_index == 0
                      && syndrome == es, "R7 double flags",
                      {syndrome, single_err, double_err, err_index}, {es, 1'b0, 1'b1, 6'd0});
                check(dec_data == (d ^ f[31:0]), "R7 double data", dec_data, d ^ f[31:0]);
            end
        end
    endtask

    task automatic test_bad(bit [31:0] d, bit [38:0] f, bit [5:0] es);
        drive(d, f, 1'b1);
        check(bad_syndrome && !single_err && !double_err && syndrome == es,
              "R8 bad flag", {syndrome, bad_syndrome}, {es, 1'b1});
        check(err_index == 0 && dec_data == (d ^ f[31:0]), "R8 bad untouched",
              {err_index, dec_data}, {6'd0, d ^ f[31:0]});
    endtask

    initial begin
        enc_data = '0; dec_word = '0; correct_en = 1'b0;
        // all-zero word: encoder and decoder idle values (R1, R9)
        test_clean(32'h0);
        test_clean(32'hFFFF_FFFF);
        test_clean(32'hA5A5_0F0F);
        for (int n = 0; n < 6; n++) test_clean($urandom);
        test_singles(32'h1234_5678, 1'b1);
        test_singles($urandom, 1'b1);
        test_singles($urandom, 1'b0);
        test_singles(32'h0, 1'b0);
        test_doubles(32'hDEAD_BEEF);
        test_doubles($urandom);
        // hc5,hc4,hc3 flipped: syndrome 1^2^4 = 7, not in map
        test_bad(32'hCAFE_F00D, (39'd1 << 37) | (39'd1 << 36) | (39'd1 << 35), 6'd7);
        // data bit 18 (6) with hc2 (8) and hc5 (1): 15, not in map
        test_bad($urandom, (39'd1 << 18) | (39'd1 << 34) | (39'd1 << 37), 6'd15);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule